// File: doc/BRIEF.md
# Latency-Hiding Thread Issue Scheduler

This block decides, every clock cycle, which of a small pool of hardware thread contexts may issue its next instruction. Each context is either ready or blocked. When an issued instruction references memory, the pipeline raises that thread's memory-request line, and the scheduler parks the thread in the blocked set. While one thread waits on memory, the others keep the pipeline busy. When the memory system hands back data for a thread, that thread rejoins the ready set.

Ready threads are served in rotating order, so none of them can starve. When the ready set is empty, the scheduler raises a stall flag instead of an issue strobe. A data return that arrives for a thread which is not waiting is treated as a protocol error. It is flagged and otherwise has no effect. Fetch, decode, register files and memory are outside the block. Memory is seen only through the request and return lines.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset every context is ready and the rotation pointer is at context 0, so the first cycle issues thread 0 with the issue strobe high, stall low and the error flag low.
- R2: The issue strobe is high exactly when at least one context is ready, and the issued thread ID always names a ready context.
- R3: The issued thread is the first ready context found by searching upward, with wrap-around, from the slot after the most recently issued thread. A cycle without issue leaves the pointer unchanged.
- R4: A memory-request bit on a ready context makes it blocked from the next cycle on.
- R5: A data-return bit on a blocked context, without a request in the same cycle, makes it ready from the next cycle on.
- R6: When a data return and a memory request hit the same context in the same cycle, the return is applied first and the request then blocks the context again, so the context is blocked in the next cycle.
- R7: With no ready context the stall flag is high, the issue strobe is low and no thread is issued.
- R8: A data return to a context that is already ready raises the error flag for exactly the following cycle. It does not change any context's state.
- R9: A memory request on an already blocked context, without a return, has no effect. The context stays blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| memReq | input | NUM_THREADS | Bit t: the instruction issued for thread t references memory |
| dataRet | input | NUM_THREADS | Bit t: memory data for thread t is now available |
| issueTid | output | TID_W | ID of the thread issued this cycle, valid with issueValid |
| issueValid | output | 1 | An instruction is issued this cycle |
| stall | output | 1 | No context is ready, nothing issues |
| retErr | output | 1 | Previous cycle saw a data return for a context that was not blocked |

## Verification
The bench builds the scheduler with the default pool of eight contexts. That pool is small enough that random blocking drains the ready set often, so stall cycles, wrap-around of the rotation pointer and refills from a single returning thread all occur many times. Directed sequences first block the whole pool. They then reach the same-cycle return-and-request case, requests to already blocked contexts, and spurious returns to ready contexts, and confirm each of them through the issue and stall outputs.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // strobes handed from the pick logic to the state datapath
  typedef struct packed {
    logic issue;
    logic stall;
  } issue_ctrl_t;
endpackage

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input  logic [N-1:0]     readyQ,
  input  logic [TID_W-1:0] rrPtr,
  output issue_ctrl_t      ctrl,
  output logic [TID_W-1:0] pickTid
);
  localparam int SUM_W = TID_W + 1;

  logic             found;
  logic [SUM_W-1:0] slot;

  // rotating search: first ready context at or after rrPtr
  always_comb begin
    found   = 1'b0;
    pickTid = '0;
    slot    = '0;
    for (int i = 0; i < N; i++) begin
      slot = {1'b0, rrPtr} + SUM_W'(i);
      if (slot >= SUM_W'(N)) slot = slot - SUM_W'(N);
      if (!found && readyQ[slot[TID_W-1:0]]) begin
        found   = 1'b1;
        pickTid = slot[TID_W-1:0];
      end
    end
    ctrl.issue = found;
    ctrl.stall = ~found;
  end
endmodule

// File: rtl/sched_state.sv
module sched_state
  import sched_pkg::*;
#(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     memReq,
  input  logic [N-1:0]     dataRet,
  input  issue_ctrl_t      ctrl,
  input  logic [TID_W-1:0] pickTid,
  output logic [N-1:0]     readyQ,
  output logic [TID_W-1:0] rrPtr,
  output logic             retErr
);
  localparam logic [TID_W-1:0] LAST = TID_W'(N - 1);

  logic [N-1:0] readyNext;

  // return applied first, then a request blocks again
  always_comb readyNext = (readyQ | dataRet) & ~memReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= '1;
      rrPtr  <= '0;
      retErr <= 1'b0;
    end else begin
      readyQ <= readyNext;
      retErr <= |(dataRet & readyQ);
      if (ctrl.issue) rrPtr <= (pickTid == LAST) ? '0 : pickTid + 1'b1;
    end
  end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] memReq,
  input  logic [NUM_THREADS-1:0] dataRet,
  output logic [TID_W-1:0]       issueTid,
  output logic                   issueValid,
  output logic                   stall,
  output logic                   retErr
);
  issue_ctrl_t            ctrl;
  logic [NUM_THREADS-1:0] readyQ;
  logic [TID_W-1:0]       rrPtr;

  sched_pick #(.N(NUM_THREADS), .TID_W(TID_W)) u_pick (
    .readyQ (readyQ),
    .rrPtr  (rrPtr),
    .ctrl   (ctrl),
    .pickTid(issueTid)
  );

  sched_state #(.N(NUM_THREADS), .TID_W(TID_W)) u_state (
    .clk    (clk),
    .rstN   (rstN),
    .memReq (memReq),
    .dataRet(dataRet),
    .ctrl   (ctrl),
    .pickTid(issueTid),
    .readyQ (readyQ),
    .rrPtr  (rrPtr),
    .retErr (retErr)
  );

  assign issueValid = ctrl.issue;
  assign stall      = ctrl.stall;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [N-1:0]     memReq,
  input logic [N-1:0]     dataRet,
  input logic [N-1:0]     readyQ,
  input logic [TID_W-1:0] issueTid,
  input logic             issueValid,
  input logic             stall,
  input logic             retErr
);
  // R2: issued thread is a ready one
  a_r2_issue_ready: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> readyQ[issueTid]);

  // R7: stall means nothing ready and nothing issued
  a_r7_stall_empty: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!issueValid && readyQ == '0));

  // R8: spurious return flagged next cycle
  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rstN)
    (|(dataRet & readyQ)) |=> retErr);

  for (genvar t = 0; t < N; t++) begin : g_thr
    // R4
    a_r4_block: assert property (@(posedge clk) disable iff (!rstN)
      (memReq[t] && readyQ[t]) |=> !readyQ[t]);
    // R5
    a_r5_wake: assert property (@(posedge clk) disable iff (!rstN)
      (dataRet[t] && !memReq[t] && !readyQ[t]) |=> readyQ[t]);
    // R6
    a_r6_reblock: assert property (@(posedge clk) disable iff (!rstN)
      (dataRet[t] && memReq[t]) |=> !readyQ[t]);
    // R9
    a_r9_req_blocked: assert property (@(posedge clk) disable iff (!rstN)
      (!readyQ[t] && memReq[t] && !dataRet[t]) |=> !readyQ[t]);
  end
endmodule

bind thread_issue_sched sched_checker #(.N(NUM_THREADS), .TID_W(TID_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .dataRet   (dataRet),
  .readyQ    (readyQ),
  .issueTid  (issueTid),
  .issueValid(issueValid),
  .stall     (stall),
  .retErr    (retErr)
);

// File: tb/test_thread_issue_sched.sv
`timescale 1ns/1ps
module test_thread_issue_sched;
  localparam int N     = 8;
  localparam int TID_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [N-1:0]     memReq = '0;
  logic [N-1:0]     dataRet = '0;
  logic [TID_W-1:0] issueTid;
  logic             issueValid;
  logic             stall;
  logic             retErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic [N-1:0]     readyM;
  logic [TID_W-1:0] ptrM;
  logic             errM;

  always #4 clk = ~clk;

  thread_issue_sched #(.NUM_THREADS(N)) i_thread_issue_sched (
    .clk(clk), .rstN(rstN), .memReq(memReq), .dataRet(dataRet),
    .issueTid(issueTid), .issueValid(issueValid), .stall(stall), .retErr(retErr)
  );

  function automatic logic [TID_W:0] pickM(input logic [N-1:0] rdy, input logic [TID_W-1:0] p);
    for (int i = 0; i < N; i++) begin
      int s = (int'(p) + i) % N;
      if (rdy[s]) return {1'b1, TID_W'(s)};
    end
    return '0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called just after a falling edge: check outputs, drive inputs, advance model
  task automatic step(input string tag, input logic [N-1:0] mr, input logic [N-1:0] dr);
    logic [TID_W:0] p;
    p = pickM(readyM, ptrM);
    chk(tag, "issueValid", int'(issueValid), int'(p[TID_W]));
    chk(tag, "stall", int'(stall), int'(!p[TID_W]));
    chk(tag, "retErr", int'(retErr), int'(errM));
    if (p[TID_W]) chk(tag, "issueTid", int'(issueTid), int'(p[TID_W-1:0]));
    memReq  = mr;
    dataRet = dr;
    errM    = |(dr & readyM);
    readyM  = (readyM | dr) & ~mr;
    if (p[TID_W]) ptrM = (int'(p[TID_W-1:0]) == N - 1) ? '0 : p[TID_W-1:0] + 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] mr, dr;
    logic [TID_W:0] p;
    void'($urandom(32'd2024));
    readyM = '1; ptrM = '0; errM = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, thread 0 first
    chk("R1", "issueTid", int'(issueTid), 0);
    chk("R1", "issueValid", int'(issueValid), 1);
    chk("R1", "retErr", int'(retErr), 0);
    // R3: plain rotation with no memory traffic
    repeat (10) step("R3", '0, '0);
    // R4: block everything, then R7 stall
    step("R4", '1, '0);
    step("R7", '0, '0);
    step("R7", '0, '0);
    // R5: wake thread 5
    step("R5", '0, 8'h20);
    chk("R5", "issueTid", int'(issueTid), 5);
    // R6: return and request on 5 together: blocked again
    step("R6", 8'h20, 8'h20);
    chk("R6", "stall", int'(stall), 1);
    // R9: request on blocked 3 keeps it blocked
    step("R9", 8'h08, '0);
    chk("R9", "stall", int'(stall), 1);
    // wake 2, then spurious return to ready 2
    step("R5", '0, 8'h04);
    chk("R5", "issueTid", int'(issueTid), 2);
    step("R8", '0, 8'h04);
    chk("R8", "retErr", int'(retErr), 1);
    chk("R8", "issueTid", int'(issueTid), 2);
    step("R8", '0, '0);
    chk("R8", "retErr", int'(retErr), 0);
    // R6 on a ready thread: flagged and blocked
    step("R6", 8'h04, 8'h04);
    chk("R6", "stall", int'(stall), 1);
    // refill pool
    step("R5", '1, '1);
    step("R5", '0, '1);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      p  = pickM(readyM, ptrM);
      mr = '0;
      dr = '0;
      if (p[TID_W] && ($urandom % 3 == 0)) mr[p[TID_W-1:0]] = 1'b1;
      if ($urandom % 10 == 0) mr[$urandom % N] = 1'b1;
      for (int t = 0; t < N; t++)
        if (!readyM[t] && ($urandom % 4 == 0)) dr[t] = 1'b1;
      if ($urandom % 20 == 0) dr[$urandom % N] = 1'b1;
      step("R3", mr, dr);
    end
    step("R3", '0, '0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule